// File: doc/BRIEF.md
# Binary range decoder with renormalization

This block is the arithmetic-decoding core of an entropy decoder. It keeps a 32-bit decoding window, a 16-bit range and a signed bit counter. It pulls compressed bytes from a byte stream that uses a valid/ready handshake. A command port starts a new stream, decodes one binary decision with a given 15-bit probability, or decodes one equiprobable decision. After every decision the block renormalizes the range and tops up the window from the stream.

A multi-symbol decoder placed next to this block can share its state. It reads the window and the range from the outputs and computes its own split point. It then issues a subtract-and-narrow command, which removes that split from the window, installs a new range and renormalizes in the same way as a binary decision.

Each byte is bit-inverted before it goes into the window. Once the stream has ended, the unfilled low bits of the window are padded with ones. Every split point keeps a small fixed margin, so neither outcome ever has zero width.

Top module: `range_bit_decoder`

## Requirements
- R1: While reset is asserted and after it is released, the window reads 0, the range reads 0x8000, cmd_ready is high, in_ready is low and result_valid is low.
- R2: A command with cmd_op = 2'b00 (start) loads window 0, range 0x8000 and counter −15, and then refills at once. No result pulse is given for it.
- R3: A refill places each byte, inverted, into the window at bit offset c = 8 − counter. Offset c drops by 8 per byte, and the refill stops once c goes negative, leaving the counter at 8 − c. While a refill waits for a byte, in_ready is high, cmd_ready is low, and the range holds its value.
- R4: If a refill finds in_eos high and no valid byte, it sets window bits c+7 down to 0 to one, sets the counter to 8 − c, and ends.
- R5: For cmd_op = 2'b01 the split is v = (((range >> 8) × (cmd_arg_a >> 6)) >> 1) + 4. If the window's upper 16 bits are ≥ v, then v is taken from them, the range becomes range − v and the bit is 0. Otherwise the range becomes v and the bit is 1.
- R6: For cmd_op = 2'b10 the split is v = ((range >> 8) << 7) + 4, and the outcome is decided as in R5.
- R7: After each decision, the window and the range shift left by d, the count of leading zeros of the new 16-bit range. The counter drops by d, so bit 15 of the range always reads 1.
- R8: A refill follows a decision only when the old counter, read as unsigned, is below d. Otherwise the command completes one cycle after acceptance.
- R9: For cmd_op = 2'b11, cmd_arg_a is subtracted from the window's upper 16 bits, the range is replaced by cmd_arg_b, and R7 and R8 apply.
- R10: result_valid pulses for one cycle per completed decision, in the first cycle that cmd_ready is high again. result_bit carries the decoded bit, which reads 0 for subtract-and-narrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 2 | 00 start, 01 bit with probability, 10 equiprobable bit, 11 subtract-and-narrow |
| cmd_arg_a | input | 16 | Probability (op 01) or split to subtract (op 11) |
| cmd_arg_b | input | 16 | New range for op 11 |
| in_data | input | 8 | Compressed byte |
| in_valid | input | 1 | in_data is valid |
| in_eos | input | 1 | Stream has no more bytes |
| in_ready | output | 1 | Byte consumed when high with in_valid |
| result_valid | output | 1 | One-cycle decision-complete pulse |
| result_bit | output | 1 | Decoded bit |
| win_o | output | 32 | Current window |
| span_o | output | 16 | Current range |

## Verification
The assertions assume three things about the inputs. A subtract-and-narrow never removes more than the window's upper 16 bits hold, and it installs a nonzero range larger than what remains. The probability for a binary decision stays below 32768, and in_eos rises only when no byte is left. The bench derives every subtract-and-narrow operand from its own model state: it takes half of the window's upper half and makes the new range equal to the old range minus that amount. Probabilities are drawn from a fixed set below 0x7F01, and the bench asserts in_eos only after the last queued byte has been consumed.

// File: rtl/range_bit_decoder.sv
module range_bit_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic [15:0] cmd_arg_a,
  input  logic [15:0] cmd_arg_b,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  input  logic        in_eos,
  output logic        in_ready,
  output logic        result_valid,
  output logic        result_bit,
  output logic [31:0] win_o,
  output logic [15:0] span_o
);
  localparam logic [1:0] OP_START = 2'b00;
  localparam logic [1:0] OP_BIT   = 2'b01;
  localparam logic [1:0] OP_EQUI  = 2'b10;
  localparam logic [1:0] OP_SUB   = 2'b11;

  logic [31:0]        dif_q;
  logic [15:0]        rng_q;
  logic signed [15:0] cnt_q;
  logic               fill_q;
  logic [4:0]         sh_q;
  logic               pend_q;
  logic               bit_q;
  logic               rv_q;

  logic [16:0]        prod;
  logic [15:0]        split;
  logic               take;
  logic [31:0]        dif_sel;
  logic [15:0]        rng_n;
  logic [4:0]         lz;
  logic [31:0]        dif_sh;
  logic [15:0]        rng_sh;
  logic signed [15:0] cnt_n;
  logic               need_fill;
  logic [15:0]        sh_calc;
  logic [31:0]        byte_ins;
  logic [31:0]        pad;

  assign cmd_ready    = !fill_q;
  assign in_ready     = fill_q;
  assign result_valid = rv_q;
  assign result_bit   = bit_q;
  assign win_o        = dif_q;
  assign span_o       = rng_q;

  assign prod = 17'(rng_q[15:8]) * 17'(cmd_arg_a[14:6]);

  always_comb begin
    case (cmd_op)
      OP_BIT:  split = 16'(prod >> 1) + 16'd4;
      OP_EQUI: split = {1'b0, rng_q[15:8], 7'd0} + 16'd4;
      default: split = cmd_arg_a;
    endcase
  end

  assign take    = (cmd_op == OP_SUB) || (dif_q[31:16] >= split);
  assign dif_sel = take ? dif_q - {split, 16'd0} : dif_q;

  always_comb begin
    if (cmd_op == OP_SUB)
      rng_n = cmd_arg_b;
    else if (take)
      rng_n = rng_q - split;
    else
      rng_n = split;
  end

  always_comb begin
    lz = 5'd16;
    for (int i = 0; i < 16; i++)
      if (rng_n[i]) lz = 5'(15 - i);
  end

  assign dif_sh    = dif_sel << lz;
  assign rng_sh    = rng_n << lz;
  assign cnt_n     = cnt_q - $signed({11'd0, lz});
  assign need_fill = $unsigned(cnt_q) < {11'd0, lz};
  assign sh_calc   = 16'd8 - $unsigned(cnt_n);
  assign byte_ins  = {24'd0, ~in_data} << sh_q;
  assign pad       = 32'hFFFF_FFFF >> (5'd24 - sh_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dif_q  <= '0;
      rng_q  <= 16'h8000;
      cnt_q  <= -16'sd15;
      fill_q <= 1'b0;
      sh_q   <= '0;
      pend_q <= 1'b0;
      bit_q  <= 1'b0;
      rv_q   <= 1'b0;
    end else begin
      rv_q <= 1'b0;
      if (!fill_q) begin
        if (cmd_valid) begin
          if (cmd_op == OP_START) begin
            dif_q  <= '0;
            rng_q  <= 16'h8000;
            cnt_q  <= -16'sd15;
            sh_q   <= 5'd23;
            fill_q <= 1'b1;
            pend_q <= 1'b0;
          end else begin
            dif_q <= dif_sh;
            rng_q <= rng_sh;
            cnt_q <= cnt_n;
            bit_q <= (cmd_op != OP_SUB) && !take;
            if (need_fill) begin
              fill_q <= 1'b1;
              sh_q   <= sh_calc[4:0];
              pend_q <= 1'b1;
            end else begin
              rv_q <= 1'b1;
            end
          end
        end
      end else if (in_valid) begin
        dif_q <= dif_q | byte_ins;
        if (sh_q < 5'd8) begin
          fill_q <= 1'b0;
          cnt_q  <= 16'd16 - {11'd0, sh_q};
          rv_q   <= pend_q;
        end else begin
          sh_q <= sh_q - 5'd8;
        end
      end else if (in_eos) begin
        dif_q  <= dif_q | pad;
        fill_q <= 1'b0;
        cnt_q  <= 16'd8 - {11'd0, sh_q};
        rv_q   <= pend_q;
      end
    end
  end

  AST_FILL_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_q) && $past(in_valid) |-> (cnt_q >= 16'sd9) && (cnt_q <= 16'sd16)); // R3
  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q && $past(fill_q) |-> $stable(rng_q)); // R3
  AST_PAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fill_q) && !$past(in_valid) |-> dif_q[7:0] == 8'hFF); // R4
  AST_RNG_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    rng_q[15]); // R7
  AST_NO_EXTRA_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && cmd_ready && cmd_op != OP_START && cnt_q < 0) |-> !fill_q); // R8
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(cmd_valid && cmd_ready && cmd_op != OP_START) || $past(fill_q)); // R10
endmodule

// File: tb/range_bit_decoder_test.sv
module range_bit_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [15:0] cmd_arg_a = '0;
  logic [15:0] cmd_arg_b = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_eos = 1'b0;
  logic        in_ready;
  logic        result_valid;
  logic        result_bit;
  logic [31:0] win_o;
  logic [15:0] span_o;

  range_bit_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg_a(cmd_arg_a), .cmd_arg_b(cmd_arg_b),
    .in_data(in_data), .in_valid(in_valid), .in_eos(in_eos), .in_ready(in_ready),
    .result_valid(result_valid), .result_bit(result_bit), .win_o(win_o), .span_o(span_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [7:0] sbytes [0:63];
  int nbytes = 0;
  int hw_idx = 0;
  int md_idx = 0;
  bit gap_mode = 1'b0;

  longint m_dif;
  int m_rng;
  int m_cnt;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    in_valid = 1'b0;
    in_eos = 1'b0;
    in_data = 8'h00;
    if (hw_idx < nbytes) begin
      if (!(gap_mode && (cyc % 3 == 0))) begin
        in_valid = 1'b1;
        in_data = sbytes[hw_idx];
      end
    end else begin
      in_eos = 1'b1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (in_valid && in_ready) hw_idx <= hw_idx + 1;
  end

  always @(posedge clk) begin
    if (cyc > 60000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<60000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic m_refill();
    int c;
    c = 8 - m_cnt;
    while (1) begin
      if (md_idx >= nbytes) begin
        m_dif = m_dif | ((~(~longint'(255) << c)) & 64'hFFFF_FFFF);
        break;
      end
      m_dif = m_dif | (longint'(sbytes[md_idx] ^ 8'hFF) << c);
      md_idx++;
      c -= 8;
      if (c < 0) break;
    end
    m_cnt = 8 - c;
  endtask

  task automatic m_decide(input int op, input int a, input int b, output int ebit, output bit efill);
    int top, v, rn, d, old;
    top = int'(m_dif >> 16);
    ebit = 0;
    if (op == 1) v = (((m_rng >> 8) * (a >> 6)) >> 1) + 4;
    else if (op == 2) v = ((m_rng >> 8) << 7) + 4;
    else v = a;
    if (op == 3) begin
      m_dif = m_dif - (longint'(v) << 16);
      rn = b;
    end else if (top >= v) begin
      m_dif = m_dif - (longint'(v) << 16);
      rn = m_rng - v;
    end else begin
      rn = v;
      ebit = 1;
    end
    d = 0;
    while (rn < 32768) begin rn = rn << 1; d++; end
    m_dif = (m_dif << d) & 64'hFFFF_FFFF;
    m_rng = rn;
    old = m_cnt;
    m_cnt = m_cnt - d;
    efill = (old >= 0) && (old < d);
    if (efill) m_refill();
  endtask

  task automatic load_stream(input int n, input int seed);
    for (int i = 0; i < n; i++) sbytes[i] = 8'((i * 37 + seed * 11 + 5) & 255);
    nbytes = n;
    hw_idx = 0;
    md_idx = 0;
  endtask

  task automatic issue(input int op, input int a, input int b);
    int ebit, waits;
    bit efill;
    if (op == 0) begin
      m_dif = 0; m_rng = 32768; m_cnt = -15;
      m_refill();
      efill = 1'b1;
      ebit = 0;
    end else begin
      m_decide(op, a, b, ebit, efill);
    end
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_arg_a = 16'(a);
    cmd_arg_b = 16'(b);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    waits = 0;
    while (!cmd_ready) begin
      if (!in_ready) check("R3 in_ready during wait", in_ready, 1);
      @(negedge clk);
      waits++;
    end
    if (op == 0) begin
      check("R2 no pulse on start", result_valid, 0);
      check("R2 start window", win_o, m_dif);
      check("R2 start range", span_o, 32768);
    end else begin
      check("R10 pulse", result_valid, 1);
      check((op == 1) ? "R5 bit" : (op == 2) ? "R6 bit" : "R9 bit", result_bit, ebit);
      check("R7 window", win_o, m_dif);
      check("R7 range", span_o, m_rng);
      check("R8 refill latency", waits > 0, efill);
    end
    @(negedge clk);
    check("R10 single pulse", result_valid, 0);
  endtask

  initial begin
    int probs [0:5];
    int a;
    probs[0] = 16'h4000; probs[1] = 16'h0100; probs[2] = 16'h7F00;
    probs[3] = 16'h2000; probs[4] = 16'h6000; probs[5] = 16'h0C40;
    repeat (3) @(negedge clk);
    check("R1 reset window", win_o, 0);
    check("R1 reset range", span_o, 16'h8000);
    check("R1 reset cmd_ready", cmd_ready, 1);
    check("R1 reset in_ready", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release range", span_o, 16'h8000);
    check("R1 after release pulse", result_valid, 0);

    load_stream(40, 1);
    issue(0, 0, 0);
    check("R3 three bytes at start", hw_idx, 3);
    for (int i = 0; i < 40; i++) begin
      if (i == 20) gap_mode = 1'b1;
      if (i % 7 == 3) issue(2, 0, 0);
      else if (i % 9 == 5) begin
        a = int'(m_dif >> 17);
        issue(3, a, m_rng - a);
      end else issue(1, probs[i % 6], 0);
    end
    gap_mode = 1'b0;

    load_stream(2, 4);
    issue(0, 0, 0);
    check("R4 padded low bits", win_o & 32'h7FFF, 32'h7FFF);
    for (int i = 0; i < 30; i++) begin
      if (i % 4 == 1) issue(2, 0, 0);
      else issue(1, probs[(i + 2) % 6], 0);
    end
    check("R4 bytes consumed", hw_idx, 2);

    load_stream(0, 0);
    issue(0, 0, 0);
    check("R4 empty stream window", win_o, 32'h7FFF_FFFF);
    issue(2, 0, 0);
    issue(1, 16'h4000, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule